// File: doc/BRIEF.md
# Dual Interval Timer on an Auxiliary Register Port

This block contains two independent 32-bit interval timers. Each timer has a count register, a two-bit control register and a limit register, all reached through a simple auxiliary-register port. The port has a write strobe, an address and write data, and it returns read data combinationally for the address currently applied.

A timer steps its count up by one on every enabled cycle. When a step happens while the count equals the limit, the count goes back to zero, so the timer runs periodically without software help. That same step sets a sticky interrupt flag if interrupt-enable is set. Software clears the flag by writing the control register, and the written value decides whether the timer keeps raising interrupts. A control bit can tie counting to a processor-halted input, so that time only advances while the processor runs.

With the limit at all ones, a timer works as a free-running monotonic counter that wraps to zero. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `aux_dual_timer`

## Requirements
- R1: After reset, every count, control and limit register reads 0, and both interrupt outputs are low.
- R2: Timer 0 count, control and limit sit at addresses 0x021, 0x022 and 0x023. Timer 1 count, control and limit sit at 0x100, 0x101 and 0x102. A write to one timer never changes the other timer's registers or interrupt.
- R3: On each enabled cycle the count increases by one. When it steps while equal to the limit, it becomes 0 instead, giving a period of limit+1 cycles.
- R4: Control bit 0 enables the interrupt. A step taken while the count equals the limit sets the timer's interrupt output one cycle later only if this bit is 1. With the bit at 0, the interrupt stays low.
- R5: Any write to a timer's control register clears that timer's interrupt at the next clock edge, whatever data is written. The clear wins over a set in the same cycle.
- R6: Once set, an interrupt stays high until a control write to that timer.
- R7: Control bit 1 is the run-only qualifier. With it set, the count does not change on cycles where halt_i is high. With it clear, halt_i has no effect.
- R8: A count write loads the written value at the next edge and overrides any step in that cycle.
- R9: With the limit at 0xFFFFFFFF, the count passes from 0xFFFFFFFE to 0xFFFFFFFF and then to 0.
- R10: Reading a control register returns interrupt-enable in bit 0 and the run-only qualifier in bit 1. All other bits read 0, and written values in those bits are discarded.
- R11: Reading any address outside the six mapped ones returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | High while the processor is halted |
| aux_we_i | input | 1 | Register write strobe |
| aux_addr_i | input | 12 | Register address for read and write |
| aux_wdata_i | input | 32 | Write data |
| aux_rdata_o | output | 32 | Read data for aux_addr_i, combinational |
| irq_o | output | 2 | Sticky interrupt per timer, bit n for timer n |

## Verification
Register writes and counter steps take effect at the clock edge that samples them, and the interrupt flag is registered too. So every count, control or interrupt change is due one edge after its cause. Read data follows the address within the same cycle. The bench applies each stimulus after a falling edge, lets one rising edge pass, and then compares the outputs a little after the next falling edge against a per-cycle arithmetic model. A sweep over several small limits on both timers steps this model cycle by cycle.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;
  // Control register layout: bit 1 run-only qualifier, bit 0 interrupt enable.
  typedef struct packed {
    logic run_only;
    logic irq_en;
  } tmr_ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_LIM  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/aux_tmr_rst_sync.sv
module aux_tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/aux_tmr_decode.sv
module aux_tmr_decode
  import aux_tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] ADDR_CNT  = BASE;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_LIM  = BASE + ADDR_W'(2);

  always_comb begin
    if (addr_i == ADDR_CNT)       sel_o = SEL_CNT;
    else if (addr_i == ADDR_CTRL) sel_o = SEL_CTRL;
    else if (addr_i == ADDR_LIM)  sel_o = SEL_LIM;
    else                          sel_o = SEL_NONE;
  end
endmodule

// File: rtl/aux_tmr_chan.sv
module aux_tmr_chan
  import aux_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              we_cnt_i,
  input  logic              we_ctrl_i,
  input  logic              we_lim_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] lim_o,
  output tmr_ctrl_t         ctrl_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d, lim_q;
  tmr_ctrl_t         ctrl_q;
  logic              irq_q, irq_d;
  logic              step, at_lim, cnt_en, irq_en;

  // Next-state logic
  always_comb begin
    step   = ~ctrl_q.run_only | ~halt_i;
    at_lim = (cnt_q == lim_q);
    cnt_en = we_cnt_i | step;
    if (we_cnt_i)    cnt_d = wdata_i;
    else if (at_lim) cnt_d = '0;
    else             cnt_d = cnt_q + DATA_W'(1);
    irq_en = we_ctrl_i | (step & ~we_cnt_i & at_lim & ctrl_q.irq_en);
    irq_d  = ~we_ctrl_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cnt_en)    cnt_q  <= cnt_d;
      if (we_lim_i)  lim_q  <= wdata_i;
      if (we_ctrl_i) ctrl_q <= tmr_ctrl_t'(wdata_i[1:0]);
      if (irq_en)    irq_q  <= irq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/aux_dual_timer.sv
module aux_dual_timer
  import aux_tmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] T0_BASE = 12'h021,
  parameter logic [ADDR_W-1:0] T1_BASE = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              aux_we_i,
  input  logic [ADDR_W-1:0] aux_addr_i,
  input  logic [DATA_W-1:0] aux_wdata_i,
  output logic [DATA_W-1:0] aux_rdata_o,
  output logic [1:0]        irq_o
);
  localparam int unsigned NUM_TMR = 2;
  localparam int unsigned CTRL_W  = $bits(tmr_ctrl_t);

  logic              rst_sync_n;
  logic [DATA_W-1:0] rd_ch [NUM_TMR];

  aux_tmr_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE = (g == 0) ? T0_BASE : T1_BASE;
    reg_sel_e          sel;
    logic [DATA_W-1:0] cnt, lim;
    tmr_ctrl_t         ctrl;

    aux_tmr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .addr_i (aux_addr_i),
      .sel_o  (sel)
    );

    aux_tmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .halt_i    (halt_i),
      .we_cnt_i  (aux_we_i && sel == SEL_CNT),
      .we_ctrl_i (aux_we_i && sel == SEL_CTRL),
      .we_lim_i  (aux_we_i && sel == SEL_LIM),
      .wdata_i   (aux_wdata_i),
      .cnt_o     (cnt),
      .lim_o     (lim),
      .ctrl_o    (ctrl),
      .irq_o     (irq_o[g])
    );

    always_comb begin
      unique case (sel)
        SEL_CNT:  rd_ch[g] = cnt;
        SEL_CTRL: rd_ch[g] = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        SEL_LIM:  rd_ch[g] = lim;
        default:  rd_ch[g] = '0;
      endcase
    end
  end

  always_comb begin
    aux_rdata_o = '0;
    for (int i = 0; i < NUM_TMR; i++) aux_rdata_o = aux_rdata_o | rd_ch[i];
  end
endmodule

// File: rtl/aux_dual_timer_chk.sv
module aux_dual_timer_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] T0_BASE = 12'h021,
  parameter logic [ADDR_W-1:0] T1_BASE = 12'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aux_we_i,
  input logic [ADDR_W-1:0] aux_addr_i,
  input logic [DATA_W-1:0] aux_wdata_i,
  input logic [DATA_W-1:0] aux_rdata_o,
  input logic [1:0]        irq_o
);
  localparam logic [ADDR_W-1:0] C0 = T0_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] L0 = T0_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] C1 = T1_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] L1 = T1_BASE + ADDR_W'(2);

  logic ctrl_wr0, ctrl_wr1, mapped, cnt0_wr;
  assign ctrl_wr0 = aux_we_i && aux_addr_i == C0;
  assign ctrl_wr1 = aux_we_i && aux_addr_i == C1;
  assign cnt0_wr  = aux_we_i && aux_addr_i == T0_BASE;
  assign mapped   = aux_addr_i == T0_BASE || aux_addr_i == C0 || aux_addr_i == L0 ||
                    aux_addr_i == T1_BASE || aux_addr_i == C1 || aux_addr_i == L1;

  assert_ack_clear0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr0 |=> !irq_o[0]);
  assert_ack_clear1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr1 |=> !irq_o[1]);
  assert_irq_sticky0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[0] && !ctrl_wr0) |=> irq_o[0]);
  assert_irq_sticky1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[1] && !ctrl_wr1) |=> irq_o[1]);
  assert_ctrl_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_addr_i == C0 || aux_addr_i == C1) |-> aux_rdata_o[DATA_W-1:2] == '0);
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> aux_rdata_o == '0);
  assert_cnt_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt0_wr) && !aux_we_i && aux_addr_i == T0_BASE) |-> aux_rdata_o == $past(aux_wdata_i));
endmodule

bind aux_dual_timer aux_dual_timer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .T0_BASE(T0_BASE), .T1_BASE(T1_BASE)
) i_aux_dual_timer_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .aux_we_i    (aux_we_i),
  .aux_addr_i  (aux_addr_i),
  .aux_wdata_i (aux_wdata_i),
  .aux_rdata_o (aux_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/test_aux_dual_timer.sv
`timescale 1ns/1ps
module test_aux_dual_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_i = 1'b0;
  logic        aux_we_i = 1'b0;
  logic [11:0] aux_addr_i = '0;
  logic [31:0] aux_wdata_i = '0;
  logic [31:0] aux_rdata_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] base [2];
  logic [31:0] lim_exp [2];

  always #2 clk = ~clk;

  aux_dual_timer i_aux_dual_timer (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .aux_we_i(aux_we_i),
    .aux_addr_i(aux_addr_i), .aux_wdata_i(aux_wdata_i),
    .aux_rdata_o(aux_rdata_o), .irq_o(irq_o)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    aux_we_i = 1'b1; aux_addr_i = a; aux_wdata_i = d;
    cyc();
    aux_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    aux_addr_i = a;
    #1;
    d = aux_rdata_o;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    bit          ir;
    base[0] = 12'h021; base[1] = 12'h100;
    lim_exp[0] = '0; lim_exp[1] = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state, R2 address map
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 3; k++) begin
        rd(base[t] + 12'(k), v);
        chk("R1 reset register", v, 32'h0);
      end
    end
    chk("R1 reset irq", {30'h0, irq_o}, 32'h0);

    // R11 unmapped reads
    begin
      logic [11:0] um [5];
      um[0] = 12'h000; um[1] = 12'h020; um[2] = 12'h024; um[3] = 12'h103; um[4] = 12'hFFF;
      for (int i = 0; i < 5; i++) begin
        rd(um[i], v);
        chk("R11 unmapped read", v, 32'h0);
      end
    end

    // R10 control readback
    wr(12'h022, 32'hFFFF_FFFF);
    rd(12'h022, v); chk("R10 ctrl readback all ones", v, 32'h3);
    wr(12'h022, 32'hFFFF_FFFC);
    rd(12'h022, v); chk("R10 ctrl readback upper discarded", v, 32'h0);
    wr(12'h101, 32'h0000_0002);
    rd(12'h101, v); chk("R10 ctrl readback run-only", v, 32'h2);
    rd(12'h022, v); chk("R2 other ctrl untouched", v, 32'h0);
    wr(12'h101, 32'h0);

    // Sweep over limits on both timers: R3, R4, R5, R6, R7, R8
    for (int t = 0; t < 2; t++) begin
      for (int lim = 0; lim <= 4; lim++) begin
        halt_i = 1'b1;
        wr(base[t] + 12'd1, 32'h2);
        wr(base[t] + 12'd2, 32'(lim));
        lim_exp[t] = 32'(lim);
        wr(base[t], 32'h0);
        wr(base[t] + 12'd1, 32'h3);
        rd(base[1-t] + 12'd2, v); chk("R2 other limit untouched", v, lim_exp[1-t]);
        chk("R5 irq clear after ctrl write", {31'h0, irq_o[t]}, 32'h0);
        c = 0; ir = 0;
        halt_i = 1'b0;
        for (int k = 0; k < 2*lim + 3; k++) begin
          cyc();
          if (c == 32'(lim)) begin c = 0; ir = 1; end else c = c + 1;
          rd(base[t], v); chk("R3 periodic count", v, c);
          chk("R4 R6 irq", {31'h0, irq_o[t]}, {31'h0, ir});
          chk("R2 other irq quiet", {31'h0, irq_o[1-t]}, 32'h0);
        end
        // ack with arbitrary data keeping run-only, IE off
        halt_i = 1'b1;
        wr(base[t] + 12'd1, 32'hFFFF_FFF2);
        chk("R5 ack clears irq", {31'h0, irq_o[t]}, 32'h0);
        halt_i = 1'b0;
        for (int k = 0; k < lim + 2; k++) begin
          cyc();
          if (c == 32'(lim)) c = 0; else c = c + 1;
          rd(base[t], v); chk("R3 count after ack", v, c);
          chk("R4 no irq with enable off", {31'h0, irq_o[t]}, 32'h0);
        end
        // R7 halt freezes count with run-only set
        halt_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
          cyc();
          rd(base[t], v); chk("R7 halted count frozen", v, c);
        end
        wr(base[t] + 12'd1, 32'h0);
        rd(base[t], v); chk("R7 frozen through ctrl write", v, c);
        for (int k = 0; k < 2; k++) begin
          cyc();
          if (c == 32'(lim)) c = 0; else c = c + 1;
          rd(base[t], v); chk("R7 halt ignored without run-only", v, c);
        end
        halt_i = 1'b0;
        // R8 count write overrides step
        wr(base[t], 32'd100);
        rd(base[t], v); chk("R8 count load", v, 32'd100);
        cyc();
        rd(base[t], v); chk("R8 count after load", v, 32'd101);
        wr(base[t] + 12'd1, 32'h0);
      end
    end

    // R9 free-running wrap at all-ones limit
    for (int t = 0; t < 2; t++) begin
      wr(base[t] + 12'd2, 32'hFFFF_FFFF);
      lim_exp[t] = 32'hFFFF_FFFF;
      wr(base[t], 32'hFFFF_FFFE);
      rd(base[t], v); chk("R9 preload", v, 32'hFFFF_FFFE);
      cyc(); rd(base[t], v); chk("R9 reach max", v, 32'hFFFF_FFFF);
      cyc(); rd(base[t], v); chk("R9 wrap to zero", v, 32'h0);
      cyc(); rd(base[t], v); chk("R9 continue", v, 32'h1);
      chk("R4 no irq on wrap with enable off", {31'h0, irq_o[t]}, 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule